// File: doc/BRIEF.md
# Calendar Update and Alarm Engine

This block keeps a binary calendar (seconds, minutes, hours, weekday, day of month, month and a two-digit year) and moves it forward by one second whenever a one-second strobe arrives while the oscillator divider field reads the run code. Each update has two phases. On the strobe the calendar steps at once and the update-in-progress flag (`uip`) goes high. After a programmable number of 32.768 kHz ticks the engine copies the calendar into the visible time bytes, clears `uip`, and emits a one-cycle set-mask that the surrounding register file ORs into its interrupt-flag register.

The visible bytes use BCD or binary coding and a 12- or 24-hour hour byte, as the format inputs select. A time write from the register file loads the calendar through the same format decoder and places the written bytes directly into the visible registers. Alarm matching compares three alarm bytes against the calendar. An alarm byte whose top two bits are both set acts as a wildcard.

The update sequencer has three states. `ST_IDLE` waits for a strobe. `ST_HOLD` counts ticks. `ST_COPY` publishes the result. The transitions are: IDLE→HOLD on an accepted strobe; HOLD→HOLD while fewer than `UPD_TICKS` ticks have been counted; HOLD→COPY on the last tick; COPY→IDLE unconditionally.

Top module: `rtc_cal_engine`

## Requirements
- R1: A strobe in `ST_IDLE` starts an update only when `div_sel` equals 3'b010. For any other value the calendar does not step, `uip` stays low and no flags are produced.
- R2: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day. The weekday wraps from 6 to 0.
- R3: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31 for months 1 to 12. Past the month's last day, mday becomes 1 and the month increments. After month 12 the month becomes 1 and the year goes from 99 to 0 or increments.
- R4: February has 29 days when the full year (CENTURY*100 + year) is divisible by 4 and not by 100, or divisible by 400. With the default CENTURY of 20, years 00 and 24 are leap years and year 01 is not.
- R5: `uip` rises on the clock after an accepted strobe, unless `set_mode` is high. It stays high through `UPD_TICKS` (default 8) ticks and the following ST_COPY cycle, and falls on the same edge that publishes the visible bytes.
- R6: With `bin_mode`=1 the visible bytes are plain binary. With `bin_mode`=0 each byte is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R7: With `h24_mode`=1 the hour byte holds 0–23. With `h24_mode`=0 it holds hour mod 12 in bits 6:0 and sets bit 7 for hours 12–23. A written hour byte is decoded the same way.
- R8: While `set_mode` is high the visible bytes are not updated by the publish step, but the calendar still advances.
- R9: If `alarm_en` is set and all three alarm bytes match when the update is published, `flag_set` carries 0xA0. A byte matches when bits 7:6 are 11 or when its decoded value equals the calendar field; the hour alarm is compared against the 0–23 hour.
- R10: When `upd_end_en` is set, every published update places 0x90 in `flag_set`, ORed with the alarm code. `flag_set` is nonzero only in the cycle after ST_COPY, and this holds whether or not `set_mode` is high.
- R11: A strobe that arrives while an update is pending (ST_HOLD or ST_COPY) is ignored.
- R12: A `wr_time` pulse loads the seven written bytes into the visible registers on the next edge and decodes them into the calendar using the current format.
- R13: After reset, `uip` and `flag_set` are 0 and the visible bytes read 00:00:00, weekday 0, day 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_strobe | input | 1 | One-cycle once-per-second pulse |
| tick_32k | input | 1 | One-cycle 32.768 kHz tick |
| div_sel | input | 3 | Oscillator divider field; 3'b010 means running |
| set_mode | input | 1 | Freeze visible registers, suppress uip |
| bin_mode | input | 1 | 1 = binary, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit 7 |
| alarm_en | input | 1 | Enable alarm flag |
| upd_end_en | input | 1 | Enable update-ended flag |
| wr_time | input | 1 | Load pulse for the written time bytes |
| wr_sec | input | 8 | Written seconds byte |
| wr_min | input | 8 | Written minutes byte |
| wr_hour | input | 8 | Written hours byte |
| wr_wday | input | 8 | Written weekday byte |
| wr_mday | input | 8 | Written day-of-month byte |
| wr_mon | input | 8 | Written month byte |
| wr_year | input | 8 | Written year byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| t_sec | output | 8 | Visible seconds |
| t_min | output | 8 | Visible minutes |
| t_hour | output | 8 | Visible hours |
| t_wday | output | 8 | Visible weekday |
| t_mday | output | 8 | Visible day of month |
| t_mon | output | 8 | Visible month |
| t_year | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| flag_set | output | 8 | One-cycle mask to OR into the interrupt flags |

## Verification
The alarm match and the update-ended flag are evaluated in the same ST_COPY cycle, so one update can raise both. A vector with wildcard-free alarm bytes equal to the new time and both enables set provokes this, and the bench requires `flag_set` to read exactly 0xB0 in the single cycle after the last tick. A second coincidence is a strobe arriving while an update is still pending. The bench fires an extra strobe in ST_HOLD and checks that the seconds byte moved by one, not two.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_COPY = 2'd2
    } upd_state_t;

    // internal binary calendar
    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    // user-visible encoded bytes
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } vis_t;

    localparam logic [7:0] FLAG_ALARM = 8'hA0;
    localparam logic [7:0] FLAG_UPD   = 8'h90;
    localparam logic [1:0] WILDCARD   = 2'b11;

    // binary value below 100 -> visible byte
    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    // visible byte -> binary value
    function automatic logic [7:0] dec_val(input logic [7:0] b, input logic bin);
        return bin ? b : (({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]});
    endfunction

    function automatic logic is_leap(input logic [6:0] yr, input int unsigned century);
        int unsigned full;
        full = century * 100 + 32'(yr);
        return (((full % 4) == 0) && ((full % 100) != 0)) || ((full % 400) == 0);
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr,
                                              input int unsigned century);
        case (mon)
            4'd2:                     return is_leap(yr, century) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
#(
    parameter int unsigned CENTURY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  cal_t load_cal,
    output cal_t cal
);

    cal_t       nxt;
    logic       c_min, c_hr, c_day, c_mon, c_yr;
    logic [4:0] dim;

    assign dim = month_days(cal.mon, cal.year, CENTURY);

    // ripple carry: sec -> min -> hour -> day -> month -> year
    always_comb begin
        nxt   = cal;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        if (({1'b0, cal.sec} + 7'd1) >= 7'd60) begin
            nxt.sec = '0;
            c_min   = 1'b1;
        end else begin
            nxt.sec = cal.sec + 6'd1;
        end

        if (c_min) begin
            if (({1'b0, cal.min} + 7'd1) >= 7'd60) begin
                nxt.min = '0;
                c_hr    = 1'b1;
            end else begin
                nxt.min = cal.min + 6'd1;
            end
        end

        if (c_hr) begin
            if (({1'b0, cal.hour} + 6'd1) >= 6'd24) begin
                nxt.hour = '0;
                c_day    = 1'b1;
            end else begin
                nxt.hour = cal.hour + 5'd1;
            end
        end

        if (c_day) begin
            nxt.wday = (({1'b0, cal.wday} + 4'd1) >= 4'd7) ? 3'd0 : cal.wday + 3'd1;
            if (({1'b0, cal.mday} + 6'd1) > {1'b0, dim}) begin
                nxt.mday = 5'd1;
                c_mon    = 1'b1;
            end else begin
                nxt.mday = cal.mday + 5'd1;
            end
        end

        if (c_mon) begin
            if (cal.mon >= 4'd12) begin
                nxt.mon = 4'd1;
                c_yr    = 1'b1;
            end else begin
                nxt.mon = cal.mon + 4'd1;
            end
        end

        if (c_yr) begin
            nxt.year = (cal.year >= 7'd99) ? 7'd0 : cal.year + 7'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal      <= '0;
            cal.mday <= 5'd1;
            cal.mon  <= 4'd1;
        end else if (load) begin
            cal <= load_cal;
        end else if (step) begin
            cal <= nxt;
        end
    end

endmodule

// File: rtl/rtc_fmt_encode.sv
module rtc_fmt_encode
    import rtc_cal_pkg::*;
(
    input  cal_t cal,
    input  logic bin_mode,
    input  logic h24_mode,
    output vis_t vis
);

    logic       pm;
    logic [6:0] h12;

    assign pm  = (cal.hour >= 5'd12);
    assign h12 = pm ? 7'(cal.hour - 5'd12) : 7'(cal.hour);

    always_comb begin
        vis.sec  = enc_val(7'(cal.sec),  bin_mode);
        vis.min  = enc_val(7'(cal.min),  bin_mode);
        vis.wday = enc_val(7'(cal.wday), bin_mode);
        vis.mday = enc_val(7'(cal.mday), bin_mode);
        vis.mon  = enc_val(7'(cal.mon),  bin_mode);
        vis.year = enc_val(cal.year,     bin_mode);
        if (h24_mode) begin
            vis.hour = enc_val(7'(cal.hour), bin_mode);
        end else begin
            vis.hour = enc_val(h12, bin_mode) | {pm, 7'd0};
        end
    end

endmodule

// File: rtl/rtc_fmt_decode.sv
module rtc_fmt_decode
    import rtc_cal_pkg::*;
(
    input  vis_t wr,
    input  logic bin_mode,
    input  logic h24_mode,
    output cal_t cal
);

    logic [7:0] hr_raw;

    assign hr_raw = dec_val(wr.hour & 8'h7F, bin_mode);

    always_comb begin
        cal.sec  = 6'(dec_val(wr.sec,  bin_mode));
        cal.min  = 6'(dec_val(wr.min,  bin_mode));
        cal.wday = 3'(dec_val(wr.wday, bin_mode));
        cal.mday = 5'(dec_val(wr.mday, bin_mode));
        cal.mon  = 4'(dec_val(wr.mon,  bin_mode));
        cal.year = 7'(dec_val(wr.year, bin_mode));
        if (!h24_mode && wr.hour[7]) begin
            cal.hour = 5'(hr_raw + 8'd12);
        end else begin
            cal.hour = 5'(hr_raw);
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  cal_t       cal,
    input  logic       bin_mode,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    output logic       hit
);

    localparam int NF = 3;

    logic [NF-1:0][7:0] alm;
    logic [NF-1:0][7:0] cur;
    logic [NF-1:0]      fld_ok;

    assign alm = {alm_hour, alm_min, alm_sec};
    assign cur = {8'(cal.hour), 8'(cal.min), 8'(cal.sec)};

    for (genvar i = 0; i < NF; i++) begin : g_fld
        assign fld_ok[i] = (alm[i][7:6] == WILDCARD) || (dec_val(alm[i], bin_mode) == cur[i]);
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/rtc_cal_engine.sv
module rtc_cal_engine
    import rtc_cal_pkg::*;
#(
    parameter int unsigned UPD_TICKS = 8,
    parameter int unsigned CENTURY   = 20,
    parameter logic [2:0]  DIV_RUN   = 3'b010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_strobe,
    input  logic       tick_32k,
    input  logic [2:0] div_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       alarm_en,
    input  logic       upd_end_en,
    input  logic       wr_time,
    input  logic [7:0] wr_sec,
    input  logic [7:0] wr_min,
    input  logic [7:0] wr_hour,
    input  logic [7:0] wr_wday,
    input  logic [7:0] wr_mday,
    input  logic [7:0] wr_mon,
    input  logic [7:0] wr_year,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    output logic [7:0] t_sec,
    output logic [7:0] t_min,
    output logic [7:0] t_hour,
    output logic [7:0] t_wday,
    output logic [7:0] t_mday,
    output logic [7:0] t_mon,
    output logic [7:0] t_year,
    output logic       uip,
    output logic [7:0] flag_set
);

    localparam int unsigned        CNT_W = (UPD_TICKS > 1) ? $clog2(UPD_TICKS) : 1;
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(UPD_TICKS - 1);

    upd_state_t       st, st_nxt;
    logic [CNT_W-1:0] cnt;
    logic             step;
    logic             alarm_hit;
    cal_t             cal, ld_cal;
    vis_t             wr_vis, enc_vis, vis_q;

    assign wr_vis = '{year: wr_year, mon: wr_mon, mday: wr_mday, wday: wr_wday,
                      hour: wr_hour, min: wr_min, sec: wr_sec};
    assign step   = (st == ST_IDLE) && sec_strobe && (div_sel == DIV_RUN) && !wr_time;

    rtc_fmt_decode u_dec (
        .wr       (wr_vis),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .cal      (ld_cal)
    );

    rtc_cal_counter #(.CENTURY(CENTURY)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (wr_time),
        .load_cal (ld_cal),
        .cal      (cal)
    );

    rtc_fmt_encode u_enc (
        .cal      (cal),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .vis      (enc_vis)
    );

    rtc_alarm_match u_alm (
        .cal      (cal),
        .bin_mode (bin_mode),
        .alm_sec  (alm_sec),
        .alm_min  (alm_min),
        .alm_hour (alm_hour),
        .hit      (alarm_hit)
    );

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (step) st_nxt = ST_HOLD;
            ST_HOLD: if (tick_32k && (cnt == LAST)) st_nxt = ST_COPY;
            ST_COPY: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st != ST_HOLD) begin
                cnt <= '0;
            end else if (tick_32k) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uip      <= 1'b0;
            flag_set <= '0;
            vis_q    <= '0;
            vis_q.mday <= 8'h01;
            vis_q.mon  <= 8'h01;
        end else begin
            flag_set <= '0;
            if (wr_time) begin
                vis_q <= wr_vis;
            end
            unique case (st)
                ST_IDLE: begin
                    if (step && !set_mode) uip <= 1'b1;
                end
                ST_HOLD: begin
                end
                ST_COPY: begin
                    uip <= 1'b0;
                    if (!set_mode && !wr_time) vis_q <= enc_vis;
                    flag_set <= ((alarm_en && alarm_hit) ? FLAG_ALARM : 8'h00) |
                                (upd_end_en ? FLAG_UPD : 8'h00);
                end
                default: begin
                end
            endcase
        end
    end

    assign t_sec  = vis_q.sec;
    assign t_min  = vis_q.min;
    assign t_hour = vis_q.hour;
    assign t_wday = vis_q.wday;
    assign t_mday = vis_q.mday;
    assign t_mon  = vis_q.mon;
    assign t_year = vis_q.year;

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
    import rtc_cal_pkg::*;
#(
    parameter logic [2:0] DIV_RUN = 3'b010
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_strobe,
    input logic       tick_32k,
    input logic [2:0] div_sel,
    input logic       set_mode,
    input logic       wr_time,
    input logic       uip,
    input logic [7:0] flag_set,
    input logic [7:0] t_sec,
    input upd_state_t st
);

    p_uip_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> ($past(sec_strobe) && !$past(set_mode)));

    p_uip_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> ($past(st) == ST_COPY));

    p_flag_after_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != 8'h00) |-> ($past(st) == ST_COPY));

    p_flag_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != 8'h00) |-> (flag_set[7] && ((flag_set & 8'h4F) == 8'h00)));

    p_set_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !wr_time) |=> $stable(t_sec));

    p_div_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && (div_sel != DIV_RUN)) |=> (st == ST_IDLE));

    p_busy_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HOLD) && !tick_32k) |=> (st == ST_HOLD));

endmodule

bind rtc_cal_engine rtc_cal_checker #(.DIV_RUN(DIV_RUN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_strobe (sec_strobe),
    .tick_32k   (tick_32k),
    .div_sel    (div_sel),
    .set_mode   (set_mode),
    .wr_time    (wr_time),
    .uip        (uip),
    .flag_set   (flag_set),
    .t_sec      (t_sec),
    .st         (st)
);

// File: tb/tb_rtc_cal_engine.sv
`timescale 1ns/1ps
module tb_rtc_cal_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_strobe = 1'b0, tick_32k = 1'b0;
    logic [2:0] div_sel = 3'b010;
    logic       set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
    logic       alarm_en = 1'b0, upd_end_en = 1'b0, wr_time = 1'b0;
    logic [7:0] wr_sec = 0, wr_min = 0, wr_hour = 0, wr_wday = 0, wr_mday = 0, wr_mon = 0, wr_year = 0;
    logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0;
    logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year, flag_set;
    logic       uip;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rtc_cal_engine dut (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .tick_32k(tick_32k),
        .div_sel(div_sel), .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .alarm_en(alarm_en), .upd_end_en(upd_end_en), .wr_time(wr_time),
        .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_wday(wr_wday),
        .wr_mday(wr_mday), .wr_mon(wr_mon), .wr_year(wr_year),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday),
        .t_mday(t_mday), .t_mon(t_mon), .t_year(t_year),
        .uip(uip), .flag_set(flag_set)
    );

    typedef struct packed {
        logic        bin;
        logic        h24;
        logic        aie;
        logic        uie;
        logic [55:0] ld;   // sec,min,hour,wday,mday,mon,year
        logic [23:0] alm;  // sec,min,hour
        logic [55:0] ex;
        logic [7:0]  fl;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        // year-end rollover, weekday 6->0, wildcard alarm (R2 R3 R9)
        '{1'b0, 1'b1, 1'b1, 1'b0, 56'h59592306311299, 24'hC0C0C0, 56'h00000000010100, 8'hA0},
        // leap February 24 (R4), update-ended (R10)
        '{1'b0, 1'b1, 1'b0, 1'b1, 56'h59592302280224, 24'h000000, 56'h00000003290224, 8'h90},
        // binary, 2023 Feb 28 -> Mar 1, alarm + update together (R6 R3 R9 R10)
        '{1'b1, 1'b1, 1'b1, 1'b1, 56'h3B3B17031C0217, 24'h000000, 56'h00000004010317, 8'hB0},
        // 12h BCD 11:59:59 AM -> 12 PM, hour alarm against 0-23 (R7 R9)
        '{1'b0, 1'b0, 1'b1, 1'b0, 56'h59591101150610, 24'hC00012, 56'h00008001150610, 8'hA0},
        // 12h BCD 11:59:59 PM -> midnight, Apr 30 -> May 1, alarm miss (R7 R3 R2)
        '{1'b0, 1'b0, 1'b1, 1'b0, 56'h59599106300410, 24'h01C0C0, 56'h00000000010510, 8'h00},
        // binary 12h 12:30:59 PM -> 12:31:00 PM (R6 R7)
        '{1'b1, 1'b0, 1'b0, 1'b0, 56'h3B1E80050A0B05, 24'h000000, 56'h001F80050A0B05, 8'h00},
        // Jun 30 -> Jul 1 (R3)
        '{1'b0, 1'b1, 1'b0, 1'b0, 56'h59592304300601, 24'h000000, 56'h00000005010701, 8'h00},
        // year 01 non-leap Feb 28 -> Mar 1 (R4)
        '{1'b0, 1'b1, 1'b0, 1'b0, 56'h59592300280201, 24'h000000, 56'h00000001010301, 8'h00},
        // exact alarm match (R9)
        '{1'b0, 1'b1, 1'b1, 1'b0, 56'h30201003050505, 24'h312010, 56'h31201003050505, 8'hA0},
        // minute alarm mismatch (R9)
        '{1'b0, 1'b1, 1'b1, 1'b0, 56'h30201003050505, 24'h312110, 56'h31201003050505, 8'h00},
        // year 00 is leap with century 20 (R4)
        '{1'b0, 1'b1, 1'b0, 1'b0, 56'h59592301280200, 24'h000000, 56'h00000002290200, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk_vis(input string req, input logic [55:0] exp);
        logic [55:0] v;
        v = {t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year};
        for (int b = 6; b >= 0; b--) begin
            chk(req, v[b*8 +: 8], exp[b*8 +: 8]);
        end
    endtask

    task automatic load_time(input logic [55:0] b);
        @(negedge clk);
        wr_time = 1'b1;
        {wr_sec, wr_min, wr_hour, wr_wday, wr_mday, wr_mon, wr_year} = b;
        @(negedge clk);
        wr_time = 1'b0;
    endtask

    task automatic pulse_strobe();
        @(negedge clk);
        sec_strobe = 1'b1;
        @(negedge clk);
        sec_strobe = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_32k = 1'b1;
            @(negedge clk);
            tick_32k = 1'b0;
        end
    endtask

    // full update; leaves the bench at the negedge where flag_set is valid
    task automatic do_second(input string req, input logic exp_uip);
        pulse_strobe();
        chk({req, " uip after strobe"}, {7'd0, uip}, {7'd0, exp_uip});
        ticks(UPD_T);
        chk({req, " uip in copy"}, {7'd0, uip}, {7'd0, exp_uip});
        @(negedge clk);
        chk({req, " uip cleared"}, {7'd0, uip}, 8'h00);
    endtask

    localparam int UPD_T = 8;

    initial begin
        #500us;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 uip", {7'd0, uip}, 8'h00);
        chk("R13 flags", flag_set, 8'h00);
        chk_vis("R13 visible", 56'h00000000010100);

        // vector table
        for (int i = 0; i < NV; i++) begin
            bin_mode   = VEC[i].bin;
            h24_mode   = VEC[i].h24;
            alarm_en   = VEC[i].aie;
            upd_end_en = VEC[i].uie;
            {alm_sec, alm_min, alm_hour} = VEC[i].alm;
            load_time(VEC[i].ld);
            chk_vis($sformatf("R12 load vec%0d", i), VEC[i].ld);
            do_second($sformatf("R5 vec%0d", i), 1'b1);
            chk($sformatf("R9/R10 flags vec%0d", i), flag_set, VEC[i].fl);
            chk_vis($sformatf("R2/R3/R4/R6/R7 vec%0d", i), VEC[i].ex);
        end

        // R1: divider not running
        bin_mode = 1'b0; h24_mode = 1'b1; alarm_en = 1'b0; upd_end_en = 1'b1;
        load_time(56'h00001001010100);
        div_sel = 3'b001;
        pulse_strobe();
        chk("R1 uip stays low", {7'd0, uip}, 8'h00);
        ticks(UPD_T);
        @(negedge clk);
        chk("R1 no advance", t_sec, 8'h00);
        chk("R1 no flags", flag_set, 8'h00);
        div_sel = 3'b010;
        do_second("R1 resumed", 1'b1);
        chk("R1 single step", t_sec, 8'h01);

        // R8: set mode freezes visible bytes, calendar still runs
        set_mode = 1'b1;
        do_second("R8 set", 1'b0);
        chk("R10 flags in set mode", flag_set, 8'h90);
        chk("R8 frozen", t_sec, 8'h01);
        set_mode = 1'b0;
        do_second("R8 release", 1'b1);
        chk("R8 calendar advanced", t_sec, 8'h03);

        // R11: second strobe while pending
        pulse_strobe();
        pulse_strobe();
        ticks(UPD_T);
        @(negedge clk);
        chk("R11 one step only", t_sec, 8'h04);
        chk("R11 uip", {7'd0, uip}, 8'h00);

        // R5: exact tick count
        pulse_strobe();
        ticks(UPD_T - 1);
        chk("R5 uip before last tick", {7'd0, uip}, 8'h01);
        chk("R5 no early copy", t_sec, 8'h04);
        ticks(1);
        chk("R5 uip in copy", {7'd0, uip}, 8'h01);
        chk("R5 not yet copied", t_sec, 8'h04);
        @(negedge clk);
        chk("R5 uip low", {7'd0, uip}, 8'h00);
        chk("R5 copied", t_sec, 8'h05);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule